// File: doc/BRIEF.md
# Chip-Select Bus Interface

This block turns internal memory requests into the strobes of an external 16-bit memory bus. A request carries a byte address in a 16 MB space, a direction and a two-bit byte-lane mask. The block picks the matching select region, runs one bus cycle (or two, for a split access) and then raises a one-cycle done flag. There are six select regions. Each region has its own base, a power-of-two span, an enable bit, and a bit that makes it a DRAM row strobe instead of a plain select. A control bit exchanges the select pins of regions 0 and 1.

Region 0 comes out of reset enabled and covers the whole space from address zero, so a processor can boot from it without any setup. The shared wait/width pin is sampled while reset is held. Its value fixes whether the device on select pin 0 is 8 or 16 bits wide. After reset the same pin stretches strobe phases. In DRAM cycles the byte-lane enables serve as column strobes, and the row and column halves of the word address share the low address bits.

Top module: `csel_bus_unit`

## Requirements
- R1: After reset all selects, write, read and lane enables are high, done is low and the bus address is zero. Region 0 is enabled at base 0 with span code 24, so it covers all addresses. Regions 1 to 5 are disabled and the swap bit is clear.
- R2: A clock with cfg_we high and cfg_idx 0..5 loads that region's base, span code, enable and DRAM bit. A region with span code s matches an address whose bits 23..s equal those of its base; a code of 24 or more matches everything. Region 0 ignores the DRAM bit and always runs generic cycles.
- R3: When several enabled regions match, the lowest-numbered one is used. A request that matches no region produces a single cycle with done high and no select, direction or lane strobe.
- R4: A generic cycle has three phases. The select goes low in the first cycle after acceptance (setup). Then comes the strobe phase, then one hold cycle in which done is high. The write enable is low only in the strobe phase of writes, and the read enable only in the strobe phase of reads.
- R5: In the generic strobe phase of a 16-bit device, the low lane enable follows mask bit 0 and the high lane enable follows mask bit 1. The bus address is the request address with bit 0 forced to 0.
- R6: Each clock edge at which the wait pin is high during a strobe phase or a DRAM column phase lengthens that phase by one cycle.
- R7: The wait pin level during reset selects the width of the device on select pin 0: 1 means 16-bit, 0 means 8-bit. For an 8-bit device, generic accesses use only the low lane enable. Mask 11 gives two full cycles, the even byte address first and then the odd one; mask 10 gives one cycle at the odd address; mask 01 gives one cycle at the even address.
- R8: A DRAM region runs three phases. The row phase has select, direction strobe and bus address = request bits 22..12 zero-extended, with no lane enable. The column phase keeps those, drives lanes per the mask and puts request bits 11..1 on the bus address. The off phase has everything high and done high.
- R9: While the swap bit is set (cfg_we with cfg_idx 6 loads it from cfg_en), region 0 drives cs_n[1] and region 1 drives cs_n[0]. Regions 2 to 5 keep their own pins. The boot width always follows pin 0.
- R10: At most one select pin is low at any time, and done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index 0..5, or 6 for the swap bit |
| cfg_base | input | 24 | Region base address |
| cfg_size | input | 5 | Region span code (log2 of bytes) |
| cfg_en | input | 1 | Region enable, or swap value when cfg_idx is 6 |
| cfg_dram | input | 1 | Region acts as a DRAM row strobe |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_addr | input | 24 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane mask, bit 0 = data bits 7..0 |
| wait_sz | input | 1 | Boot width during reset, wait request afterwards |
| req_done | output | 1 | One-cycle completion flag |
| cs_n | output | 6 | Active-low select pins |
| we_n | output | 1 | Active-low write enable |
| oe_n | output | 1 | Active-low read enable |
| ble_n | output | 1 | Active-low low-lane enable / low column strobe |
| bhe_n | output | 1 | Active-low high-lane enable / high column strobe |
| bus_addr | output | 24 | External address, row/column multiplexed in DRAM cycles |

## Verification
The hardest state to reach from the ports is an 8-bit boot device that sits on pin 0 only because of the swap. This needs a reset taken with the wait pin held low, then region 1 configured and swapped, then a two-lane access with wait pulses inside both strobe phases. The bench re-runs reset with both pin levels to reach this state. It drives the wait pin at the falling edge of each strobe cycle, as its own model of the phase sequence dictates, so lengthened phases are checked cycle by cycle. Random region layouts with overlapping spans, DRAM bits and swap settings then exercise priority and pin mapping.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_ROW,
    PH_COL,
    PH_OFF,
    PH_MISS
  } phase_t;
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/csel_region_file.sv
module csel_region_file #(
  parameter int NREG = 6,
  parameter int AW   = 24,
  parameter int SZW  = 5,
  localparam int IW  = $clog2(NREG + 1),
  localparam int PW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [AW-1:0]  cfg_base,
  input  logic [SZW-1:0] cfg_size,
  input  logic           cfg_en,
  input  logic           cfg_dram,
  input  logic [AW-1:0]  look_addr,
  output logic           any_hit,
  output logic [PW-1:0]  win_idx,
  output logic           win_dram,
  output logic           swap
);
  logic [AW-1:0]  base_q [NREG];
  logic [SZW-1:0] size_q [NREG];
  logic [NREG-1:0] en_q, dram_q, wr_sel, match;
  logic swap_q, swap_we;

  always_comb begin
    for (int i = 0; i < NREG; i++) wr_sel[i] = cfg_we && (cfg_idx == IW'(i));
    swap_we = cfg_we && (cfg_idx == IW'(NREG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        size_q[i] <= (i == 0) ? SZW'(AW) : '0;
      end
      en_q   <= NREG'(1);
      dram_q <= '0;
      swap_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_sel[i]) begin
          base_q[i] <= cfg_base;
          size_q[i] <= cfg_size;
          en_q[i]   <= cfg_en;
          dram_q[i] <= (i == 0) ? 1'b0 : cfg_dram;
        end
      end
      if (swap_we) swap_q <= cfg_en;
    end
  end

  // one comparator per region, span given as a keep mask on upper bits
  for (genvar g = 0; g < NREG; g++) begin : g_match
    logic [AW-1:0] keep_m;
    always_comb begin
      for (int b = 0; b < AW; b++) keep_m[b] = (b >= int'(size_q[g]));
    end
    assign match[g] = en_q[g] && (((look_addr ^ base_q[g]) & keep_m) == '0);
  end

  // lowest index wins: scan from the top so the last write is the lowest
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_dram = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_hit  = 1'b1;
        win_idx  = PW'(i);
        win_dram = dram_q[i];
      end
    end
  end

  assign swap = swap_q;
endmodule

// File: rtl/csel_cycle_fsm.sv
module csel_cycle_fsm
  import csel_pkg::*;
#(
  parameter int NREG  = 6,
  parameter int AW    = 24,
  parameter int COL_W = 11,
  localparam int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_be,
  input  logic          hit,
  input  logic [PW-1:0] hit_pin,
  input  logic          hit_dram,
  input  logic          boot16,
  input  logic          wait_in,
  output logic [NREG-1:0] cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          ble_n,
  output logic          bhe_n,
  output logic [AW-1:0] bus_addr,
  output logic          done
);
  phase_t ph_q, ph_d;
  logic [PW-1:0] pin_q;
  logic          wr_q, narrow_q, lane_q, lane_d, more_q, more_d;
  logic [1:0]    be_q, lanes;
  logic [AW-1:1] addr_q;
  logic          take, narrow_now, sel_on, drive;
  logic [AW-1:0] addr_o;

  assign take       = (ph_q == PH_IDLE) && req_valid;
  assign narrow_now = !boot16 && (hit_pin == '0) && !hit_dram;

  // next-state
  always_comb begin
    ph_d   = ph_q;
    lane_d = lane_q;
    more_d = more_q;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        if (!hit)          ph_d = PH_MISS;
        else if (hit_dram) ph_d = PH_ROW;
        else               ph_d = PH_SETUP;
        lane_d = narrow_now && (req_be == 2'b10);
        more_d = narrow_now && (req_be == 2'b11);
      end
      PH_SETUP:  ph_d = PH_STROBE;
      PH_STROBE: if (!wait_in) ph_d = PH_HOLD;
      PH_HOLD: begin
        if (more_q) begin
          ph_d   = PH_SETUP;
          lane_d = 1'b1;
          more_d = 1'b0;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_ROW: ph_d = PH_COL;
      PH_COL: if (!wait_in) ph_d = PH_OFF;
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      lane_q   <= 1'b0;
      more_q   <= 1'b0;
      pin_q    <= '0;
      wr_q     <= 1'b0;
      be_q     <= 2'b00;
      addr_q   <= '0;
      narrow_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      lane_q <= lane_d;
      more_q <= more_d;
      if (take) begin
        pin_q    <= hit_pin;
        wr_q     <= req_write;
        be_q     <= req_be;
        addr_q   <= req_addr[AW-1:1];
        narrow_q <= narrow_now;
      end
    end
  end

  // strobe decode
  always_comb begin
    sel_on = ph_q inside {PH_SETUP, PH_STROBE, PH_HOLD, PH_ROW, PH_COL};
    drive  = ph_q inside {PH_STROBE, PH_ROW, PH_COL};
    lanes  = 2'b00;
    if (ph_q == PH_STROBE)
      lanes = narrow_q ? {1'b0, (lane_q ? be_q[1] : be_q[0])} : be_q;
    else if (ph_q == PH_COL)
      lanes = be_q;
    case (ph_q)
      PH_SETUP, PH_STROBE, PH_HOLD: addr_o = {addr_q[AW-1:1], narrow_q & lane_q};
      PH_ROW:  addr_o = AW'(addr_q[2*COL_W:COL_W+1]);
      PH_COL:  addr_o = AW'(addr_q[COL_W:1]);
      default: addr_o = '0;
    endcase
  end

  assign cs_n     = ~(sel_on ? (NREG'(1) << pin_q) : NREG'(0));
  assign we_n     = ~(drive && wr_q);
  assign oe_n     = ~(drive && !wr_q);
  assign ble_n    = ~lanes[0];
  assign bhe_n    = ~lanes[1];
  assign bus_addr = addr_o;
  assign done     = ((ph_q == PH_HOLD) && !more_q) || (ph_q == PH_OFF) || (ph_q == PH_MISS);
endmodule

// File: rtl/csel_bus_unit.sv
module csel_bus_unit #(
  parameter int NREG  = 6,
  parameter int AW    = 24,
  parameter int SZW   = 5,
  parameter int COL_W = 11,
  localparam int IW   = $clog2(NREG + 1),
  localparam int PW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [SZW-1:0]  cfg_size,
  input  logic            cfg_en,
  input  logic            cfg_dram,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [1:0]      req_be,
  input  logic            wait_sz,
  output logic            req_done,
  output logic [NREG-1:0] cs_n,
  output logic            we_n,
  output logic            oe_n,
  output logic            ble_n,
  output logic            bhe_n,
  output logic [AW-1:0]   bus_addr
);
  logic          rst_s, boot16_q, any_hit, win_dram, swap;
  logic [PW-1:0] win_idx, pin;

  csel_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  // width strap: follows the shared pin for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rst_s) boot16_q <= wait_sz;
  end

  csel_region_file #(.NREG(NREG), .AW(AW), .SZW(SZW)) u_regions (
    .clk       (clk),
    .rst_n     (rst_s),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .cfg_en    (cfg_en),
    .cfg_dram  (cfg_dram),
    .look_addr (req_addr),
    .any_hit   (any_hit),
    .win_idx   (win_idx),
    .win_dram  (win_dram),
    .swap      (swap)
  );

  assign pin = (swap && (win_idx < PW'(2))) ? (win_idx ^ PW'(1)) : win_idx;

  csel_cycle_fsm #(.NREG(NREG), .AW(AW), .COL_W(COL_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_be    (req_be),
    .hit       (any_hit),
    .hit_pin   (pin),
    .hit_dram  (win_dram),
    .boot16    (boot16_q),
    .wait_in   (wait_sz),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .ble_n     (ble_n),
    .bhe_n     (bhe_n),
    .bus_addr  (bus_addr),
    .done      (req_done)
  );
endmodule

// File: rtl/csel_bus_checks.sv
module csel_bus_checks #(
  parameter int NREG = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] cs_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            ble_n,
  input logic            bhe_n,
  input logic            wait_sz,
  input logic            req_done
);
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R10
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R4
  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !(&cs_n)); // R4
  AST_LANES_NEED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ble_n || !bhe_n) |-> !(&cs_n)); // R5
  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!we_n || !oe_n) && wait_sz) |=> ((!we_n || !oe_n) && $stable(cs_n))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R10
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (&cs_n)); // R4
endmodule

bind csel_bus_unit csel_bus_checks #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .ble_n    (ble_n),
  .bhe_n    (bhe_n),
  .wait_sz  (wait_sz),
  .req_done (req_done)
);

// File: tb/csel_bus_unit_test.sv
module csel_bus_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni, cfg_we, cfg_en, cfg_dram, req_valid, req_write, wait_sz;
  logic [2:0]  cfg_idx;
  logic [23:0] cfg_base, req_addr, bus_addr;
  logic [4:0]  cfg_size;
  logic [1:0]  req_be;
  logic        req_done, we_n, oe_n, ble_n, bhe_n;
  logic [5:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [23:0] m_base [6];
  int          m_size [6];
  bit          m_en [6];
  bit          m_dram [6];
  bit          m_swap, m_boot16;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_bus_unit uut (
    .clk(clk), .rst_ni(rst_ni), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_en(cfg_en), .cfg_dram(cfg_dram),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .wait_sz(wait_sz), .req_done(req_done), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .ble_n(ble_n), .bhe_n(bhe_n), .bus_addr(bus_addr)
  );

  function automatic bit covers(input int i, input logic [23:0] a);
    if (!m_en[i]) return 0;
    if (m_size[i] >= 24) return 1;
    return (a >> m_size[i]) == (m_base[i] >> m_size[i]);
  endfunction

  function automatic int exp_region(input logic [23:0] a);
    for (int i = 0; i < 6; i++) if (covers(i, a)) return i;
    return -1;
  endfunction

  task automatic cmp(input logic [5:0] ecs, input logic ewe, input logic eoe,
                     input logic eble, input logic ebhe, input logic [23:0] eaddr,
                     input bit use_addr, input logic edone, input string tag);
    logic [34:0] act, exp;
    act = {cs_n, we_n, oe_n, ble_n, bhe_n, (use_addr ? bus_addr : 24'h0), req_done};
    exp = {ecs, ewe, eoe, eble, ebhe, (use_addr ? eaddr : 24'h0), edone};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
    checks++;
    if ($countones(~cs_n) > 1) begin
      errors++;
      $display("FAIL R10: actual cs_n %b expected at most one low", cs_n);
    end
  endtask

  task automatic do_reset(input logic boot);
    rst_ni = 1'b0; wait_sz = boot; req_valid = 1'b0; cfg_we = 1'b0;
    req_addr = '0; req_write = 1'b0; req_be = 2'b00;
    cfg_idx = '0; cfg_base = '0; cfg_size = '0; cfg_en = 1'b0; cfg_dram = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    wait_sz = 1'b0;
    for (int i = 0; i < 6; i++) begin
      m_base[i] = '0; m_size[i] = (i == 0) ? 24 : 0; m_en[i] = (i == 0); m_dram[i] = 0;
    end
    m_swap = 0; m_boot16 = boot;
  endtask

  task automatic cfg(input int idx, input logic [23:0] b, input int sz, input bit en, input bit dr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_size = 5'(sz); cfg_en = en; cfg_dram = dr;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 6) begin
      m_base[idx] = b; m_size[idx] = sz; m_en[idx] = en; m_dram[idx] = (idx == 0) ? 0 : dr;
    end else begin
      m_swap = en;
    end
  endtask

  task automatic access(input logic [23:0] a, input bit wr, input logic [1:0] be,
                        input int nw, input string tag);
    int r, pin, nbeats;
    bit narrow;
    logic [5:0] ecs;
    logic ewe, eoe;
    int lanes_l [2];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    r = exp_region(a);
    if (r < 0) begin
      cmp(6'h3f, 1, 1, 1, 1, 24'h0, 1, 1, tag);
      return;
    end
    pin = (m_swap && r < 2) ? (r ^ 1) : r;
    ecs = ~(6'b1 << pin);
    ewe = !wr; eoe = wr;
    if (m_dram[r]) begin
      cmp(ecs, ewe, eoe, 1, 1, {13'h0, a[22:12]}, 1, 0, tag);
      for (int k = 0; k <= nw; k++) begin
        @(negedge clk);
        cmp(ecs, ewe, eoe, !be[0], !be[1], {13'h0, a[11:1]}, 1, 0, tag);
        wait_sz = (k < nw);
      end
      @(negedge clk);
      wait_sz = 1'b0;
      cmp(6'h3f, 1, 1, 1, 1, 24'h0, 0, 1, tag);
      return;
    end
    narrow = !m_boot16 && (pin == 0);
    if (narrow && be == 2'b11) begin nbeats = 2; lanes_l[0] = 0; lanes_l[1] = 1; end
    else if (narrow && be == 2'b10) begin nbeats = 1; lanes_l[0] = 1; lanes_l[1] = 0; end
    else begin nbeats = 1; lanes_l[0] = 0; lanes_l[1] = 0; end
    for (int b = 0; b < nbeats; b++) begin
      logic [23:0] ea;
      logic el, eh;
      ea = narrow ? {a[23:1], 1'(lanes_l[b])} : {a[23:1], 1'b0};
      el = narrow ? !be[lanes_l[b]] : !be[0];
      eh = narrow ? 1'b1 : !be[1];
      if (b > 0) @(negedge clk);
      cmp(ecs, 1, 1, 1, 1, ea, 1, 0, tag);
      for (int k = 0; k <= nw; k++) begin
        @(negedge clk);
        cmp(ecs, ewe, eoe, el, eh, ea, 1, 0, tag);
        wait_sz = (k < nw);
      end
      @(negedge clk);
      wait_sz = 1'b0;
      cmp(ecs, 1, 1, 1, 1, ea, 1, (b == nbeats - 1), tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10: watchdog expired, actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state with a 16-bit boot strap
    do_reset(1'b1);
    cmp(6'h3f, 1, 1, 1, 1, 24'h0, 1, 0, "R1");
    access(24'hFEDCBA, 0, 2'b11, 0, "R1");
    access(24'h000123, 1, 2'b01, 0, "R4");
    access(24'h012346, 0, 2'b10, 0, "R5");
    access(24'h0A0A0A, 1, 2'b11, 3, "R6");
    // R2 / R3: shrink region 0, overlapping regions 1 and 2
    cfg(0, 24'h000000, 16, 1, 1);
    cfg(1, 24'h100000, 20, 1, 0);
    cfg(2, 24'h100000, 16, 1, 0);
    access(24'h100040, 0, 2'b11, 0, "R3");
    access(24'h1F0040, 1, 2'b11, 1, "R2");
    access(24'h800000, 0, 2'b11, 0, "R3");
    access(24'h00FFFE, 1, 2'b11, 0, "R2");
    cfg(2, 24'h100000, 16, 0, 0);
    access(24'h200000, 0, 2'b01, 0, "R3");
    // R8: DRAM region
    cfg(3, 24'h400000, 22, 1, 1);
    access(24'h5ABCDE, 0, 2'b11, 0, "R8");
    access(24'h7FF002, 1, 2'b10, 2, "R8");
    // R9: swap
    cfg(6, 24'h0, 0, 1, 0);
    access(24'h000010, 0, 2'b11, 0, "R9");
    access(24'h150000, 1, 2'b01, 1, "R9");
    access(24'h400100, 0, 2'b01, 0, "R9");
    // R7: 8-bit boot strap
    do_reset(1'b0);
    cmp(6'h3f, 1, 1, 1, 1, 24'h0, 1, 0, "R1");
    access(24'h000200, 0, 2'b11, 0, "R7");
    access(24'h000300, 1, 2'b11, 2, "R7");
    access(24'h000400, 0, 2'b10, 0, "R7");
    access(24'h000500, 1, 2'b01, 1, "R7");
    cfg(0, 24'h000000, 12, 1, 0);
    cfg(1, 24'h020000, 16, 1, 0);
    access(24'h020000, 0, 2'b11, 0, "R7");
    cfg(6, 24'h0, 0, 1, 0);
    access(24'h020020, 1, 2'b11, 1, "R9");
    access(24'h000020, 0, 2'b11, 0, "R9");
    // random layouts
    for (int round = 0; round < 6; round++) begin
      do_reset(1'($urandom % 2));
      cfg(0, 24'h000000, 12 + ($urandom % 8), 1, 0);
      for (int i = 1; i < 6; i++)
        cfg(i, 24'($urandom), 12 + ($urandom % 12), 1'($urandom % 4 != 0), 1'($urandom % 2));
      cfg(6, 24'h0, 0, 1'($urandom % 2), 0);
      for (int n = 0; n < 25; n++) begin
        int rr;
        logic [23:0] a, msk;
        rr = int'($urandom % 7);
        if (rr < 6) begin
          msk = (m_size[rr] >= 24) ? 24'hFFFFFF : ((24'h1 << m_size[rr]) - 24'h1);
          a = (m_base[rr] & ~msk) | (24'($urandom) & msk);
        end else begin
          a = 24'($urandom);
        end
        access(a, 1'($urandom % 2), 2'(1 + ($urandom % 3)), int'($urandom % 4), "R3");
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule